// File: doc/BRIEF.md
# Cycle-Skipping On/Off Switch Controller

This block drives the gate of a power switch with on/off control instead of a pulse-width loop. At every cycle-start pulse from the oscillator it looks at a hysteretic feedback-disable flag. If feedback allows it and no protection is active, the switch turns on for that cycle. If not, the whole cycle is skipped. Once the switch is on, it stays on until one of three things happens: the current-limit comparator trips after the leading-edge blanking window, the maximum-duty window closes, or a protection or restart permit withdraws.

The feedback, supply and thermal inputs each arrive as a pair of digital threshold flags. A small set/clear latch inside the block turns each pair into a hysteretic state. Every cycle that feedback skips produces a one-tick pulse, which a restart watchdog uses to tell a regulating loop from a faulted one. The blanking length is a parameter counted in reference-clock ticks.

Top module: `onoff_switch_ctrl`

## Requirements
- R1: While rst_ni is low, gate_o and skip_o are 0. Reset leaves the supply fault latched, so no cycle fires until supply_ok_i has been seen high for at least one edge.
- R2: If cycle_start_i is high at an edge, the feedback-disable latch is clear, dmax_i and permit_i are high and no supply or thermal fault is latched, then gate_o is 1 after that edge.
- R3: While the switch is on, changes of the feedback flags do not alter gate_o. Feedback is sampled only at cycle-start edges.
- R4: A cycle-start edge that finds the feedback-disable latch set leaves gate_o at 0. It also raises skip_o for exactly the one tick after that edge.
- R5: The current-limit flag ilim_i is ignored at the BLANK_TICKS edges that follow the edge raising gate_o. If it is held high, gate_o falls at edge BLANK_TICKS+1.
- R6: After a current-limit turn-off, gate_o stays 0 until the next firing cycle-start edge, even when ilim_i returns low.
- R7: dmax_i low at an edge forces gate_o to 0 after that edge.
- R8: The feedback-disable latch sets when en_trip_hi_i is 1. It stays set while en_trip_lo_i is 1 and clears at an edge where both flags are 0.
- R9: The supply fault latch sets on supply_low_i and clears only on supply_ok_i. While it is set, no cycle fires and a running on-time ends by the second edge after supply_low_i rises.
- R10: The thermal fault latch sets on temp_hot_i and clears only on temp_cool_i. It blocks firing and ends on-time in the same way as R9.
- R11: permit_i low at an edge prevents firing and ends a running on-time after that edge.
- R12: When a turn-off request and a turn-on request meet at the same edge, turn-off wins. A cycle-start that coincides with an unblanked current limit leaves gate_o at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_start_i | input | 1 | One-tick pulse at the start of each switching cycle |
| dmax_i | input | 1 | High while on-time is permitted within the cycle |
| en_trip_hi_i | input | 1 | Feedback pull-down above the upper threshold |
| en_trip_lo_i | input | 1 | Feedback pull-down above the lower threshold |
| ilim_i | input | 1 | Switch current above limit |
| supply_low_i | input | 1 | Internal supply below its low threshold |
| supply_ok_i | input | 1 | Internal supply above its high threshold |
| temp_hot_i | input | 1 | Die temperature above shutdown threshold |
| temp_cool_i | input | 1 | Die temperature below re-enable threshold |
| permit_i | input | 1 | Switching permitted by the restart logic |
| gate_o | output | 1 | Gate drive request |
| skip_o | output | 1 | One-tick pulse per cycle skipped by feedback |

## Verification
The bench builds the block with BLANK_TICKS set to 3. With that value, every masked edge of the blanking window can be checked one by one, along with the first edge at which the current limit is honoured. The short window also expires early enough that a fresh cycle-start can meet an unblanked current limit while the switch is still on. That makes the off-over-on priority observable at the ports, and hysteresis holds and releases can be shown within a few ticks.

// File: rtl/onoff_pkg.sv
package onoff_pkg;
  localparam int unsigned NGUARD = 3;
  localparam int unsigned GI_EN  = 0;
  localparam int unsigned GI_UV  = 1;
  localparam int unsigned GI_OT  = 2;
  // supply fault starts latched: no switching before the supply is good
  localparam logic [NGUARD-1:0] GUARD_RST = 3'b010;
endpackage

// File: rtl/onoff_hyst_flag.sv
module onoff_hyst_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= RST_VAL;
    else if (set_i)  flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/onoff_blank_timer.sv
module onoff_blank_timer #(
  parameter int unsigned TICKS = 43
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(TICKS + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CW'(TICKS);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/onoff_ontime_latch.sv
module onoff_ontime_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_req_i,
  input  logic off_req_i,
  output logic on_o
);
  logic on_q;

  // off has priority over on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         on_q <= 1'b0;
    else if (off_req_i)  on_q <= 1'b0;
    else if (on_req_i)   on_q <= 1'b1;
  end

  assign on_o = on_q;
endmodule

// File: rtl/onoff_switch_ctrl.sv
module onoff_switch_ctrl
  import onoff_pkg::*;
#(
  parameter int unsigned BLANK_TICKS = 43
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cycle_start_i,
  input  logic dmax_i,
  input  logic en_trip_hi_i,
  input  logic en_trip_lo_i,
  input  logic ilim_i,
  input  logic supply_low_i,
  input  logic supply_ok_i,
  input  logic temp_hot_i,
  input  logic temp_cool_i,
  input  logic permit_i,
  output logic gate_o,
  output logic skip_o
);
  logic [NGUARD-1:0] g_set, g_clr, guard_q;
  logic gate_q, blank_busy, fire, lim_off, off_req, turn_on, skip_q;

  assign g_set = {temp_hot_i,  supply_low_i, en_trip_hi_i};
  assign g_clr = {temp_cool_i, supply_ok_i,  ~en_trip_lo_i};

  for (genvar g = 0; g < NGUARD; g++) begin : g_guard
    onoff_hyst_flag #(.RST_VAL(GUARD_RST[g])) u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (g_set[g]),
      .clr_i (g_clr[g]),
      .flag_o(guard_q[g])
    );
  end

  assign fire = cycle_start_i & ~guard_q[GI_EN] & dmax_i & permit_i;

  // current limit only counts once blanking has expired
  assign lim_off = gate_q & ilim_i & ~blank_busy;
  assign off_req = ~dmax_i | ~permit_i | guard_q[GI_UV] | guard_q[GI_OT] | lim_off;
  assign turn_on = fire & ~off_req;

  onoff_ontime_latch u_ontime (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .on_req_i (fire),
    .off_req_i(off_req),
    .on_o     (gate_q)
  );

  onoff_blank_timer #(.TICKS(BLANK_TICKS)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(turn_on),
    .busy_o(blank_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) skip_q <= 1'b0;
    else         skip_q <= cycle_start_i & guard_q[GI_EN];
  end

  assign gate_o = gate_q;
  assign skip_o = skip_q;
endmodule

// File: rtl/onoff_switch_ctrl_chk.sv
module onoff_switch_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cycle_start_i,
  input logic dmax_i,
  input logic ilim_i,
  input logic permit_i,
  input logic gate_o,
  input logic skip_o,
  input logic blank_busy_i,
  input logic uv_fault_i,
  input logic ot_fault_i
);
  a_r2_rise_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_o) |-> $past(cycle_start_i));

  a_r4_skip_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> $past(cycle_start_i));

  a_r5_blank_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && blank_busy_i && dmax_i && permit_i && !uv_fault_i && !ot_fault_i) |=> gate_o);

  a_r6_limit_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o && !blank_busy_i && ilim_i) |=> !gate_o);

  a_r7_dmax_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dmax_i |=> !gate_o);

  a_r9_uv_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_fault_i |=> !gate_o);

  a_r10_ot_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_fault_i |=> !gate_o);

  a_r11_permit_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !permit_i |=> !gate_o);
endmodule

bind onoff_switch_ctrl onoff_switch_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cycle_start_i(cycle_start_i),
  .dmax_i       (dmax_i),
  .ilim_i       (ilim_i),
  .permit_i     (permit_i),
  .gate_o       (gate_o),
  .skip_o       (skip_o),
  .blank_busy_i (blank_busy),
  .uv_fault_i   (guard_q[1]),
  .ot_fault_i   (guard_q[2])
);

// File: tb/tb_onoff_switch_ctrl.sv
`timescale 1ns/1ps
module tb_onoff_switch_ctrl;
  localparam int unsigned BLANK = 3;
  localparam int NROWS = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cs, dmax, dhi, dlo, ilim, perm, bpl, bph, hot, cool;
  logic gate, skip;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  onoff_switch_ctrl #(.BLANK_TICKS(BLANK)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cycle_start_i(cs), .dmax_i(dmax),
    .en_trip_hi_i(dhi), .en_trip_lo_i(dlo), .ilim_i(ilim),
    .supply_low_i(bpl), .supply_ok_i(bph), .temp_hot_i(hot), .temp_cool_i(cool),
    .permit_i(perm), .gate_o(gate), .skip_o(skip)
  );

  // [15:6] {cs,dmax,dhi,dlo,ilim,perm,bpl,bph,hot,cool} [5] gate [4] skip [3:0] req
  localparam logic [15:0] TBL [NROWS] = '{
    16'b0100010101_00_1001, // R9 supply ok clears fault
    16'b1100010101_10_0010, // R2 fire
    16'b0100010101_10_0010, // R2 hold
    16'b0111010101_10_0011, // R3 feedback trips mid-cycle
    16'b0101010101_10_0011, // R3
    16'b0001010101_00_0111, // R7 dmax closes
    16'b1101010101_01_0100, // R4 skipped, R8 held by low flag
    16'b0101010101_00_0100, // R4 pulse is one tick
    16'b0100010101_00_1000, // R8 clears
    16'b1100010101_10_1000, // R8 enabled again
    16'b0100110101_10_0101, // R5 masked edge 1
    16'b0100110101_10_0101, // R5 masked edge 2
    16'b0100110101_10_0101, // R5 masked edge 3
    16'b0100110101_00_0101, // R5 honoured
    16'b0100010101_00_0110, // R6 stays off
    16'b1100010101_10_0010, // R2 new cycle
    16'b0100010101_10_0010,
    16'b0100010101_10_0010,
    16'b0100010101_10_0010, // blanking expired
    16'b1100110101_00_1100, // R12 off wins
    16'b0100010101_00_0110, // R6
    16'b1100000101_00_1011, // R11 no fire
    16'b1100010101_10_1011, // R11 fire
    16'b0100000101_00_1011  // R11 ends on-time
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0b exp=%0b", req, what, act, exp);
    end
  endtask

  task automatic idle();
    {cs, dmax, dhi, dlo, ilim, perm, bpl, bph, hot, cool} = 10'b0100010101;
  endtask

  initial begin
    idle();
    bph = 1'b0;
    #1;
    chk("R1", "gate in reset", gate, 1'b0);
    chk("R1", "skip in reset", skip, 1'b0);
    repeat (2) tick();
    rst_ni = 1'b1;
    tick();
    cs = 1'b1;
    tick();
    chk("R1", "no fire before supply ok", gate, 1'b0);
    chk("R1", "no skip", skip, 1'b0);
    cs = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      {cs, dmax, dhi, dlo, ilim, perm, bpl, bph, hot, cool} = TBL[i][15:6];
      tick();
      chk($sformatf("R%0d", TBL[i][3:0]), $sformatf("row %0d gate", i), gate, TBL[i][5]);
      chk($sformatf("R%0d", TBL[i][3:0]), $sformatf("row %0d skip", i), skip, TBL[i][4]);
    end

    // R9 supply hysteresis
    idle(); bpl = 1'b1; bph = 1'b0; tick();
    bpl = 1'b0; cs = 1'b1; tick();
    chk("R9", "fault held between thresholds", gate, 1'b0);
    cs = 1'b0; bph = 1'b1; tick();
    cs = 1'b1; tick();
    chk("R9", "fires after supply ok", gate, 1'b1);
    cs = 1'b0; bpl = 1'b1; bph = 1'b0; tick(); tick();
    chk("R9", "low supply ends on-time", gate, 1'b0);
    idle(); tick();

    // R10 thermal hysteresis
    hot = 1'b1; cool = 1'b0; tick();
    hot = 1'b0; cs = 1'b1; tick();
    chk("R10", "fault held while warm", gate, 1'b0);
    cs = 1'b0; cool = 1'b1; tick();
    cs = 1'b1; tick();
    chk("R10", "fires after cooling", gate, 1'b1);
    cs = 1'b0; hot = 1'b1; cool = 1'b0; tick(); tick();
    chk("R10", "hot ends on-time", gate, 1'b0);
    idle(); tick();

    // R1 async reset during on-time
    cs = 1'b1; tick(); cs = 1'b0;
    chk("R1", "on before reset", gate, 1'b1);
    rst_ni = 1'b0;
    #1;
    chk("R1", "reset clears gate", gate, 1'b0);
    chk("R1", "reset clears skip", skip, 1'b0);
    tick();
    rst_ni = 1'b1;
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule